// File: doc/BRIEF.md
# Eight-Stage In-Order Pipeline Interlock

This block is the control section of an eight-stage, in-order instruction pipeline. Its stages are fetch-address, fetch, decode, operand-address resolve, operand-address issue, operand read, execute and write-back. It carries no arithmetic and no memory. Each instruction enters as a small descriptor: an optional operand read address, an optional result write address and a tag. The block moves descriptors one stage per cycle and shows which stages are occupied. It produces the operand-read strobe in the address-issue stage, the memory-write strobe in the write-back stage, and the retirement of each instruction.

The pipeline protects itself against read-after-write hazards through memory. In the address-issue stage, an instruction that reads memory has its address compared with the write addresses of the valid instructions in the three later stages. On a match the instruction waits, together with every stage in front of it. Empty slots go into the operand-read stage until the conflicting write has left write-back. Results therefore always appear in program order, and no software scheduling is needed. A parameter can narrow the address comparison to its low bits. This gives a cheaper comparator, at the cost of some stalls that are not needed.

Top module: `pipe8_interlock`

## Requirements
- R1: After reset every stage is empty, no stage is stalled, `in_ready` is 1 and `retire_valid` is 0.
- R2: A descriptor presented with `in_valid` while `in_ready` is 1 is taken at that clock edge. If it meets no hazard, it is retired (`retire_valid` 1 with its tag) in the seventh cycle after the cycle in which it was taken.
- R3: An instruction whose read flag is 0 never stalls, whatever its read address.
- R4: An instruction in the address-issue stage (index 4) stalls when its read flag is 1 and its read address equals the write address of a valid, write-flagged instruction in stage 5, 6 or 7.
- R5: While stalled, stages 0 to 4 hold their contents and report `stage_stall` 1, stages 5 to 7 report 0, and `in_ready` is 0.
- R6: Each stall cycle places an empty slot into stage 5 on the next cycle.
- R7: A stalled reader leaves the address-issue stage in the cycle after the conflicting writer has left write-back. A reader d instructions behind its writer (d below 4) therefore loses 4-d cycles, and it retires exactly 4 cycles after that writer.
- R8: Instructions retire one at a time, in the order they were taken, with none lost or duplicated.
- R9: `mem_wr_en` is 1 exactly when the retiring instruction has its write flag set, and `mem_wr_addr` then carries its write address.
- R10: `opr_rd_en` pulses for one cycle, with `opr_rd_addr`, in the cycle a read-flagged instruction leaves the address-issue stage.
- R11: A writer whose write flag is 0, or whose write address differs from the read address, causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Fetch-address stage can take a descriptor |
| in_rd_en | input | 1 | Instruction reads an operand from memory |
| in_rd_addr | input | ADDR_W | Operand read address |
| in_wr_en | input | 1 | Instruction writes its result to memory |
| in_wr_addr | input | ADDR_W | Result write address |
| in_tag | input | TAG_W | Identifier carried to retirement |
| stage_valid | output | 8 | Occupancy per stage, bit 0 = fetch-address, bit 7 = write-back |
| stage_stall | output | 8 | Stage held this cycle |
| opr_rd_en | output | 1 | Operand address issued |
| opr_rd_addr | output | ADDR_W | Issued operand address |
| mem_wr_en | output | 1 | Result written this cycle |
| mem_wr_addr | output | ADDR_W | Result write address |
| retire_valid | output | 1 | Instruction completes write-back this cycle |
| retire_tag | output | TAG_W | Tag of the retiring instruction |

## Verification
The bench feeds each group of instructions continuously. Timing is measured from the edge that takes the first one, which then reaches the address-issue stage in cycle 4. From that starting point the bench computes, for every instruction, the cycle it leaves that stage: one cycle after its predecessor, but no earlier than four cycles after any earlier conflicting writer left it. The read strobe is due in that cycle and retirement three cycles later. `in_ready` falls in each cycle from arrival to departure, and the empty slot shows in stage 5 one cycle after each stall cycle. Outputs are sampled on the falling edge, and every cycle is checked, whether an event is due in it or not.

// File: rtl/pipe8_pkg.sv
package pipe8_pkg;
   localparam int NSTG = 8;

   typedef enum int {
      ST_FA = 0,
      ST_FE = 1,
      ST_DC = 2,
      ST_AR = 3,
      ST_AI = 4,
      ST_OR = 5,
      ST_EX = 6,
      ST_WB = 7
   } stage_e;

   // stages whose pending write can collide with the address-issue read
   localparam int N_WCHK = int'(ST_WB) - int'(ST_AI);
endpackage

// File: rtl/pipe8_stage.sv
module pipe8_stage #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold,
   input  logic          kill,
   input  logic          d_valid,
   input  logic [DW-1:0] d_data,
   output logic          q_valid,
   output logic [DW-1:0] q_data
);
   if (DW < 1) begin : g_bad_dw
      $error("pipe8_stage: DW must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_data  <= '0;
      end else if (!hold) begin
         q_valid <= d_valid & ~kill;
         q_data  <= d_data;
      end
   end
endmodule

// File: rtl/pipe8_hazard.sv
module pipe8_hazard #(
   parameter int ADDR_W = 8,
   parameter int CMP_W  = ADDR_W,
   parameter int NW     = 3
) (
   input  logic                       rd_req,
   input  logic [ADDR_W-1:0]          rd_addr,
   input  logic [NW-1:0]              wr_live,
   input  logic [NW-1:0][ADDR_W-1:0]  wr_addr,
   output logic                       hit
);
   if (CMP_W < 1 || CMP_W > ADDR_W) begin : g_bad_cmp
      $error("pipe8_hazard: CMP_W must lie in 1..ADDR_W");
   end
   if (NW < 1) begin : g_bad_nw
      $error("pipe8_hazard: NW must be positive");
   end

   logic [NW-1:0] match;

   for (genvar k = 0; k < NW; k++) begin : g_cmp
      if (CMP_W == ADDR_W) begin : g_full
         assign match[k] = wr_live[k] && (wr_addr[k] == rd_addr);
      end else begin : g_part
         // narrow compare: aliasing only adds stalls, never drops one
         assign match[k] = wr_live[k] &&
                           (wr_addr[k][CMP_W-1:0] == rd_addr[CMP_W-1:0]);
      end
   end

   assign hit = rd_req && (|match);
endmodule

// File: rtl/pipe8_interlock.sv
module pipe8_interlock
   import pipe8_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int TAG_W  = 8,
   parameter int CMP_W  = ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_rd_en,
   input  logic [ADDR_W-1:0] in_rd_addr,
   input  logic              in_wr_en,
   input  logic [ADDR_W-1:0] in_wr_addr,
   input  logic [TAG_W-1:0]  in_tag,
   output logic [7:0]        stage_valid,
   output logic [7:0]        stage_stall,
   output logic              opr_rd_en,
   output logic [ADDR_W-1:0] opr_rd_addr,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic              retire_valid,
   output logic [TAG_W-1:0]  retire_tag
);
   // descriptor layout, low to high: tag, write address, write flag,
   // read address, read flag
   localparam int TAG_LO = 0;
   localparam int WA_LO  = TAG_LO + TAG_W;
   localparam int WE_B   = WA_LO + ADDR_W;
   localparam int RA_LO  = WE_B + 1;
   localparam int RE_B   = RA_LO + ADDR_W;
   localparam int DW     = RE_B + 1;
   localparam int HOLD_LAST = int'(ST_AI);
   localparam int BUBBLE_AT = int'(ST_OR);

   if (ADDR_W < 1) begin : g_bad_addr
      $error("pipe8_interlock: ADDR_W must be positive");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("pipe8_interlock: TAG_W must be positive");
   end
   if (NSTG != 8) begin : g_bad_nstg
      $error("pipe8_interlock: stage count is fixed at eight");
   end

   logic [NSTG-1:0] v;
   logic [DW-1:0]   dat [NSTG];
   logic [DW-1:0]   in_desc;
   logic            stall;

   assign in_desc = {in_rd_en, in_rd_addr, in_wr_en, in_wr_addr, in_tag};

   for (genvar s = 0; s < NSTG; s++) begin : g_stg
      logic          d_v;
      logic [DW-1:0] d_d;
      if (s == 0) begin : g_head
         assign d_v = in_valid;
         assign d_d = in_desc;
      end else begin : g_link
         assign d_v = v[s-1];
         assign d_d = dat[s-1];
      end

      logic hold_s;
      logic kill_s;
      if (s <= HOLD_LAST) begin : g_front
         assign hold_s = stall;
         assign kill_s = 1'b0;
      end else if (s == BUBBLE_AT) begin : g_bub
         assign hold_s = 1'b0;
         assign kill_s = stall;
      end else begin : g_back
         assign hold_s = 1'b0;
         assign kill_s = 1'b0;
      end

      pipe8_stage #(.DW(DW)) u_stg (
         .clk     (clk),
         .rst_n   (rst_n),
         .hold    (hold_s),
         .kill    (kill_s),
         .d_valid (d_v),
         .d_data  (d_d),
         .q_valid (v[s]),
         .q_data  (dat[s])
      );

      assign stage_stall[s] = (s <= HOLD_LAST) ? stall : 1'b0;
   end

   // writers pending downstream of the address-issue stage
   logic [N_WCHK-1:0]             wlive;
   logic [N_WCHK-1:0][ADDR_W-1:0] waddr;

   for (genvar k = 0; k < N_WCHK; k++) begin : g_wsrc
      localparam int SI = int'(ST_AI) + 1 + k;
      assign wlive[k] = v[SI] && dat[SI][WE_B];
      assign waddr[k] = dat[SI][WA_LO +: ADDR_W];
   end

   logic ai_rd;
   assign ai_rd = v[ST_AI] && dat[ST_AI][RE_B];

   pipe8_hazard #(
      .ADDR_W (ADDR_W),
      .CMP_W  (CMP_W),
      .NW     (N_WCHK)
   ) u_haz (
      .rd_req  (ai_rd),
      .rd_addr (dat[ST_AI][RA_LO +: ADDR_W]),
      .wr_live (wlive),
      .wr_addr (waddr),
      .hit     (stall)
   );

   assign in_ready     = ~stall;
   assign stage_valid  = v;
   assign opr_rd_en    = ai_rd && !stall;
   assign opr_rd_addr  = dat[ST_AI][RA_LO +: ADDR_W];
   assign mem_wr_en    = v[ST_WB] && dat[ST_WB][WE_B];
   assign mem_wr_addr  = dat[ST_WB][WA_LO +: ADDR_W];
   assign retire_valid = v[ST_WB];
   assign retire_tag   = dat[ST_WB][TAG_LO +: TAG_W];
endmodule

// File: rtl/pipe8_interlock_chk.sv
module pipe8_interlock_chk
   import pipe8_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int TAG_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_ready,
   input logic [7:0]        stage_valid,
   input logic [7:0]        stage_stall,
   input logic              opr_rd_en,
   input logic [ADDR_W-1:0] opr_rd_addr,
   input logic              mem_wr_en,
   input logic [ADDR_W-1:0] mem_wr_addr,
   input logic              retire_valid,
   input logic [TAG_W-1:0]  retire_tag
);
   p_front_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stage_stall[ST_AI] |-> (&stage_stall[4:0]) && !in_ready
                             && (stage_stall[7:5] == 3'b000));

   p_hold_occupied_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stage_stall[ST_AI] |=> stage_valid[ST_AI]);

   p_empty_no_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !stage_valid[ST_AI] |-> !stage_stall[ST_AI]);

   p_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stage_stall[ST_AI] |=> !stage_valid[ST_OR]);

   p_wr_at_retire_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> retire_valid);

   p_rd_leaves_r10: assert property (@(posedge clk) disable iff (!rst_n)
      opr_rd_en |-> stage_valid[ST_AI] && !stage_stall[ST_AI]);

   p_retire_from_ex_r8: assert property (@(posedge clk) disable iff (!rst_n)
      retire_valid |-> $past(stage_valid[ST_EX]));
endmodule

bind pipe8_interlock pipe8_interlock_chk #(
   .ADDR_W (ADDR_W),
   .TAG_W  (TAG_W)
) u_chk (.*);

// File: tb/sim_pipe8_interlock.sv
module sim_pipe8_interlock;
   localparam int AW   = 2;
   localparam int TW   = 8;
   localparam int MAXN = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic          in_rd_en = 1'b0;
   logic [AW-1:0] in_rd_addr = '0;
   logic          in_wr_en = 1'b0;
   logic [AW-1:0] in_wr_addr = '0;
   logic [TW-1:0] in_tag = '0;
   logic [7:0]    stage_valid;
   logic [7:0]    stage_stall;
   logic          opr_rd_en;
   logic [AW-1:0] opr_rd_addr;
   logic          mem_wr_en;
   logic [AW-1:0] mem_wr_addr;
   logic          retire_valid;
   logic [TW-1:0] retire_tag;

   pipe8_interlock #(.ADDR_W(AW), .TAG_W(TW)) u0 (.*);

   always #2 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int gtag = 0;
   int unsigned seed = 32'h1234_5678;

   bit       s_rd [MAXN];
   bit [1:0] s_ra [MAXN];
   bit       s_wr [MAXN];
   bit [1:0] s_wa [MAXN];
   int       s_tg [MAXN];
   int       e_t  [MAXN];
   int       a_t  [MAXN];
   bit       st_rel [256];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   function automatic int unsigned nxt(input int unsigned x);
      int unsigned y;
      y = x ^ (x << 13);
      y = y ^ (y >> 17);
      y = y ^ (y << 5);
      return y;
   endfunction

   task automatic run_seg(input int n, input string lbl);
      int b, rt, ptr, rp, qp, tend;
      for (int c = 0; c < 256; c++) st_rel[c] = 1'b0;
      // exit time from address-issue stage, relative to first accept edge
      for (int i = 0; i < n; i++) begin
         a_t[i] = (i == 0) ? 4 : e_t[i-1] + 1;
         e_t[i] = a_t[i];
         for (int j = 0; j < i; j++)
            if (s_wr[j] && s_rd[i] && s_wa[j] == s_ra[i] && e_t[j] + 4 > e_t[i])
               e_t[i] = e_t[j] + 4;
         for (int c = a_t[i]; c < e_t[i]; c++) st_rel[c] = 1'b1;
      end
      tend = e_t[n-1] + 5;
      ptr = 0; rp = 0; qp = 0;
      while (qp < n && !s_rd[qp]) qp++;
      @(negedge clk);
      b = cyc + 1;
      for (int t = 0; t <= tend + 1; t++) begin
         rt = cyc - b;
         if (rt >= 0) begin
            if (rp < n && e_t[rp] + 3 == rt) begin
               chk(retire_valid == 1'b1, (e_t[rp] > a_t[rp]) ? "R7 retire" : "R2 retire",
                   int'(retire_valid), 1);
               chk(retire_tag == TW'(s_tg[rp]), "R8 order", int'(retire_tag), s_tg[rp] & 255);
               chk(mem_wr_en == s_wr[rp] && (!s_wr[rp] || mem_wr_addr == s_wa[rp]),
                   "R9 write", int'(mem_wr_addr), int'(s_wa[rp]));
               rp++;
            end else begin
               chk(retire_valid == 1'b0, "R8 no extra retire", int'(retire_valid), 0);
            end
            if (qp < n && e_t[qp] == rt) begin
               chk(opr_rd_en == 1'b1 && opr_rd_addr == s_ra[qp], "R10 read strobe",
                   int'(opr_rd_addr), int'(s_ra[qp]));
               qp++;
               while (qp < n && !s_rd[qp]) qp++;
            end else begin
               chk(opr_rd_en == 1'b0, "R10 read quiet", int'(opr_rd_en), 0);
            end
            chk(in_ready == !st_rel[rt], {lbl, " R4 stall"}, int'(in_ready), int'(!st_rel[rt]));
            chk(stage_stall == (st_rel[rt] ? 8'h1F : 8'h00), "R5 stall vector",
                int'(stage_stall), st_rel[rt] ? 31 : 0);
            if (rt > 0 && st_rel[rt-1])
               chk(stage_valid[5] == 1'b0, "R6 bubble", int'(stage_valid[5]), 0);
         end
         if (ptr < n) begin
            in_valid   = 1'b1;
            in_rd_en   = s_rd[ptr];
            in_rd_addr = s_ra[ptr];
            in_wr_en   = s_wr[ptr];
            in_wr_addr = s_wa[ptr];
            in_tag     = TW'(s_tg[ptr]);
            if (in_ready) ptr++;
         end else begin
            in_valid = 1'b0;
         end
         @(negedge clk);
      end
      chk(rp == n && ptr == n, "R8 all retired", rp, n);
      chk(stage_valid == 8'h00, "R8 drained", int'(stage_valid), 0);
   endtask

   task automatic put(input int i, input bit rd, input int ra, input bit wr, input int wa);
      s_rd[i] = rd; s_ra[i] = 2'(ra); s_wr[i] = wr; s_wa[i] = 2'(wa);
      s_tg[i] = gtag & 255; gtag++;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog at cycle %0d: actual=hung expected=finished", cyc);
         summary();
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(stage_valid == 8'h00 && stage_stall == 8'h00, "R1 reset stages",
          int'(stage_valid), 0);
      chk(in_ready == 1'b1 && retire_valid == 1'b0, "R1 reset ready",
          int'(in_ready), 1);

      put(0, 0, 0, 1, 2);
      run_seg(1, "R2");

      // writer then reader at distance d = 1..5
      for (int d = 1; d <= 5; d++) begin
         put(0, 0, 0, 1, 1);
         for (int f = 1; f < d; f++) put(f, 0, 0, 0, 0);
         put(d, 1, 1, 0, 0);
         run_seg(d + 1, "R7");
      end

      // reader flag off with matching address
      put(0, 0, 0, 1, 2); put(1, 0, 2, 0, 0); put(2, 0, 2, 1, 2);
      run_seg(3, "R3");

      // writer flag off, and address mismatch
      put(0, 0, 0, 0, 3); put(1, 1, 3, 0, 0);
      put(2, 0, 0, 1, 1); put(3, 1, 2, 0, 0);
      run_seg(4, "R11");

      // chained dependences
      put(0, 0, 0, 1, 1); put(1, 1, 1, 1, 2); put(2, 1, 2, 1, 3); put(3, 1, 3, 0, 0);
      run_seg(4, "R4 chain");

      // pseudo-random segments over a four-word address space
      for (int g = 0; g < 60; g++) begin
         int n;
         seed = nxt(seed);
         n = 1 + int'(seed % 16);
         for (int i = 0; i < n; i++) begin
            seed = nxt(seed);
            put(i, seed[0], int'(seed[3:2]), seed[1], int'(seed[5:4]));
         end
         run_seg(n, "R4 sweep");
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule